// File: doc/BRIEF.md
# External Event Interrupt Status Register

This block watches eight active-low event lines from outside the chip. It raises a system management interrupt when a line that software has armed goes from high to low. Each line first passes through a two-flop synchronizer. A falling-edge detector then compares the synchronized level with its value from the previous cycle, and a detected edge on an armed line latches a per-line status flag.

Software sees one 32-bit register. The low byte holds the per-line arm bits. The per-line status flags appear twice: once in a field that clears when the register is read, and once in a mirror field whose own definition is read-only. A single read strobe clears every flag, so both views drop together. An edge that lands in the same cycle as the clearing read is kept. The interrupt output, and a summary bit meant for a separate top-level status register, stay high while any flag is set.

The register port is a plain select/write/read strobe interface. Read data is presented continuously. A read strobe sampled at a clock edge clears the status, and a write strobe updates the arm bits at that edge.

Top module: `ext_evt_smi_ctrl`

## Requirements
- R1: After synchronous reset, the whole register reads 0, `smi_out` and `smi_summary` are low, and every synchronizer and edge-history flop holds the inactive high level, so lines held high across reset produce no event.
- R2: A write strobe loads bus_wdata[7:0] into the arm bits (bit n arms line n). Written values in bits 31:8 have no effect, and bits 31:24 always read 0.
- R3: A high-to-low transition on an armed line n sets status bit 16+n. The bit is visible on the third rising clock edge after the input changes and not before.
- R4: A falling edge on a line whose arm bit is 0 sets no status. Arming the line afterwards does not create a late event.
- R5: A rising edge, or a line held low, sets no status.
- R6: Bits 15:8 always equal bits 23:16.
- R7: A read strobe returns the register with its status still set and clears all status bits (23:16 and 15:8) at that clock edge.
- R8: A status bit whose edge is detected in the same cycle as a clearing read is set after that read and not lost.
- R9: `smi_out` and `smi_summary` are high exactly when any status bit is set.
- R10: Lines are independent. Simultaneous falling edges on several armed lines set each matching bit, and only those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_rd | input | 1 | Read strobe, clears status (with bus_sel) |
| bus_wdata | input | 32 | Write data, only bits 7:0 used |
| bus_rdata | output | 32 | Register contents: 23:16 clear-on-read status, 15:8 status mirror, 7:0 arm bits |
| evt_n_in | input | 8 | Active-low asynchronous event lines |
| smi_out | output | 1 | Interrupt request, high while any status bit is set |
| smi_summary | output | 1 | Summary status bit for the top-level status register |

## Verification
Status follows an input transition by exactly three rising edges: two synchronizer stages, then the status flop. The bench drives lines at a falling clock edge and samples once after two rising edges, where it expects no change, and again after the third, where it expects the new status. Writes and read-clears take effect at the single rising edge that samples the strobe. The bench therefore samples `bus_rdata` at the falling edge before that rising edge for the returned value and at the falling edge after it for the new state. For the coincident-read case, the read strobe is placed in the cycle where the synchronized edge is already detected and its status flop has not yet loaded.

// File: rtl/ext_evt_pkg.sv
package ext_evt_pkg;

    parameter int unsigned EVT_LINES  = 8;
    parameter int unsigned BUS_W      = 32;
    parameter int unsigned SYNC_DEPTH = 2;

    localparam int unsigned ARM_LSB    = 0;
    localparam int unsigned MIRROR_LSB = ARM_LSB + EVT_LINES;
    localparam int unsigned CLEAR_LSB  = MIRROR_LSB + EVT_LINES;
    localparam int unsigned USED_BITS  = CLEAR_LSB + EVT_LINES;

    typedef logic [EVT_LINES-1:0] evt_vec_t;
    typedef logic [BUS_W-1:0]     bus_word_t;

    typedef struct packed {
        logic     load;
        evt_vec_t value;
    } arm_wr_t;

    typedef struct packed {
        evt_vec_t set_mask;
        logic     clear_all;
    } stat_upd_t;

    function automatic bus_word_t pack_view(evt_vec_t arm, evt_vec_t stat);
        bus_word_t w;
        w = '0;
        w[ARM_LSB    +: EVT_LINES] = arm;
        w[MIRROR_LSB +: EVT_LINES] = stat;
        w[CLEAR_LSB  +: EVT_LINES] = stat;
        return w;
    endfunction

    function automatic evt_vec_t stat_next(evt_vec_t cur, stat_upd_t u);
        evt_vec_t kept;
        kept = u.clear_all ? '0 : cur;
        return kept | u.set_mask;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync
    import ext_evt_pkg::*;
#(
    parameter int unsigned WIDTH  = EVT_LINES,
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_n,
    output logic [WIDTH-1:0] sync_n
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_line
            logic [STAGES-1:0] chain;
            if (STAGES == 1) begin : g_one
                always_ff @(posedge clk) begin
                    if (rst) chain <= '1;
                    else     chain <= raw_n[i];
                end
            end else begin : g_many
                always_ff @(posedge clk) begin
                    if (rst) chain <= '1;
                    else     chain <= {chain[STAGES-2:0], raw_n[i]};
                end
            end
            assign sync_n[i] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/evt_fall_detect.sv
module evt_fall_detect
    import ext_evt_pkg::*;
#(
    parameter int unsigned WIDTH = EVT_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_n,
    input  logic [WIDTH-1:0] arm,
    output logic [WIDTH-1:0] fall_hit
);

    logic [WIDTH-1:0] hist_n;

    always_ff @(posedge clk) begin
        if (rst) hist_n <= '1;
        else     hist_n <= lvl_n;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_det
            assign fall_hit[i] = hist_n[i] & ~lvl_n[i] & arm[i];
        end
    endgenerate

endmodule

// File: rtl/evt_arm_reg.sv
module evt_arm_reg
    import ext_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  arm_wr_t  wr,
    output evt_vec_t arm
);

    always_ff @(posedge clk) begin
        if (rst)          arm <= '0;
        else if (wr.load) arm <= wr.value;
    end

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
    import ext_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stat_upd_t upd,
    output evt_vec_t  stat,
    output logic      any_set
);

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= stat_next(stat, upd);
    end

    assign any_set = |stat;

endmodule

// File: rtl/ext_evt_smi_ctrl.sv
module ext_evt_smi_ctrl
    import ext_evt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [EVT_LINES-1:0] evt_n_in,
    output logic                 smi_out,
    output logic                 smi_summary
);

    evt_vec_t  sync_n;
    evt_vec_t  arm;
    evt_vec_t  fall_hit;
    evt_vec_t  stat;
    logic      any_set;
    arm_wr_t   arm_wr;
    stat_upd_t stat_upd;
    logic      unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:EVT_LINES];

    assign arm_wr.load  = bus_sel & bus_wr;
    assign arm_wr.value = bus_wdata[ARM_LSB +: EVT_LINES];

    assign stat_upd.set_mask  = fall_hit;
    assign stat_upd.clear_all = bus_sel & bus_rd;

    evt_sync #(.WIDTH(EVT_LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_n  (evt_n_in),
        .sync_n (sync_n)
    );

    evt_fall_detect #(.WIDTH(EVT_LINES)) u_fall (
        .clk      (clk),
        .rst      (rst),
        .lvl_n    (sync_n),
        .arm      (arm),
        .fall_hit (fall_hit)
    );

    evt_arm_reg u_arm (
        .clk (clk),
        .rst (rst),
        .wr  (arm_wr),
        .arm (arm)
    );

    evt_status_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .upd     (stat_upd),
        .stat    (stat),
        .any_set (any_set)
    );

    assign bus_rdata   = pack_view(arm, stat);
    assign smi_out     = any_set;
    assign smi_summary = any_set;

endmodule

// File: rtl/ext_evt_smi_chk.sv
module ext_evt_smi_chk
    import ext_evt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic                 smi_out,
    input logic                 smi_summary
);

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0 && !smi_out && !smi_summary));

    // R2
    top_byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:USED_BITS] == '0);

    // R2
    arm_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr) |=> bus_rdata[ARM_LSB +: EVT_LINES] == $past(bus_wdata[ARM_LSB +: EVT_LINES]));

    // R6
    mirror_equal_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[MIRROR_LSB +: EVT_LINES] == bus_rdata[CLEAR_LSB +: EVT_LINES]);

    // R9
    smi_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (smi_out == (|bus_rdata[CLEAR_LSB +: EVT_LINES])) && (smi_summary == smi_out));

    // R4
    no_unarmed_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((bus_rdata[CLEAR_LSB +: EVT_LINES]
                   & ~$past(bus_rdata[CLEAR_LSB +: EVT_LINES])
                   & ~$past(bus_rdata[ARM_LSB +: EVT_LINES])) == '0));

endmodule

bind ext_evt_smi_ctrl ext_evt_smi_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .smi_out     (smi_out),
    .smi_summary (smi_summary)
);

// File: tb/ext_evt_smi_ctrl_bench.sv
module ext_evt_smi_ctrl_bench;

    logic        clk;
    logic        rst;
    logic        bus_sel;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_n_in;
    logic        smi_out;
    logic        smi_summary;

    int checks;
    int fails;
    bit done;

    // {arm, lines that fall}
    localparam logic [15:0] VEC_TAB [8] = '{
        16'hFF_01, 16'hFF_80, 16'h0F_FF, 16'hF0_FF,
        16'hAA_55, 16'hAA_FF, 16'h00_FF, 16'hFF_FF
    };

    ext_evt_smi_ctrl u_ext_evt_smi_ctrl (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .evt_n_in    (evt_n_in),
        .smi_out     (smi_out),
        .smi_summary (smi_summary)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v;
        tick(1);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(output logic [31:0] v);
        bus_sel = 1'b1; bus_rd = 1'b1;
        v = bus_rdata;
        tick(1);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] view(input logic [7:0] arm, input logic [7:0] st);
        return {8'h00, st, st, arm};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [7:0]  exp;
        checks = 0; fails = 0; done = 0;
        rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; evt_n_in = 8'hFF;
        tick(3);
        rst = 1'b0;
        chk("R1 reset register", bus_rdata, 32'h0);
        chk("R1 reset smi", {30'h0, smi_out, smi_summary}, 32'h0);
        bus_write(32'h0000_00FF);
        tick(5);
        chk("R1 no event from reset history", bus_rdata, view(8'hFF, 8'h00));

        for (int i = 0; i < 8; i++) begin
            bus_write({24'h0, VEC_TAB[i][15:8]});
            evt_n_in = 8'hFF;
            tick(4);
            exp = VEC_TAB[i][15:8] & VEC_TAB[i][7:0];
            evt_n_in = ~VEC_TAB[i][7:0];
            tick(2);
            chk("R3 not before third edge", bus_rdata, view(VEC_TAB[i][15:8], 8'h00));
            tick(1);
            chk("R10 status bits", bus_rdata, view(VEC_TAB[i][15:8], exp));
            chk("R9 smi level", {30'h0, smi_out, smi_summary}, (exp != 0) ? 32'h3 : 32'h0);
            bus_read(rv);
            chk("R7 read returns set status", rv, view(VEC_TAB[i][15:8], exp));
            chk("R7 read clears", bus_rdata, view(VEC_TAB[i][15:8], 8'h00));
            chk("R9 smi drops", {31'h0, smi_out}, 32'h0);
            evt_n_in = 8'hFF;
            tick(4);
            chk("R5 rising edge no event", bus_rdata, view(VEC_TAB[i][15:8], 8'h00));
        end

        // R4: disabled fall, then late arm
        bus_write(32'h0);
        evt_n_in = 8'hFB;
        tick(5);
        chk("R4 unarmed fall ignored", bus_rdata, 32'h0);
        bus_write(32'h0000_0004);
        tick(5);
        chk("R4 no late event", bus_rdata, view(8'h04, 8'h00));
        chk("R5 steady low no event", {31'h0, smi_out}, 32'h0);
        evt_n_in = 8'hFF;
        tick(4);

        // R2: upper bits ignored while status is set
        bus_write(32'h0000_0003);
        evt_n_in = 8'hFE;
        tick(3);
        bus_write(32'hFFFF_FF03);
        chk("R2 upper write ignored", bus_rdata, view(8'h03, 8'h01));
        bus_write(32'h5A00_0003);
        chk("R2 top byte zero", bus_rdata, view(8'h03, 8'h01));

        // R8: edge detected in the cycle of a clearing read
        evt_n_in = 8'hFC;
        tick(2);
        bus_read(rv);
        chk("R8 read value before set", rv, view(8'h03, 8'h01));
        chk("R8 coincident edge kept", bus_rdata, view(8'h03, 8'h02));
        chk("R6 mirror after coincident", {24'h0, bus_rdata[15:8]}, {24'h0, bus_rdata[23:16]});
        bus_read(rv);
        chk("R7 final clear", bus_rdata, view(8'h03, 8'h00));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule